// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

The block collects level-sensitive interrupt inputs from up to 31 peripherals and turns them into a single request line for a host processor. Software programs it through a small word-addressed register bus. The registers are a configuration word, a source enable mask, an in-service set and a vector latch. When the host takes an interrupt, it writes the acknowledge bit of the vector latch and then reads back the number of the winning source. That source is moved into the in-service set, and software later retires it by writing a one to its in-service bit.

Arbitration is fixed: the lower source number wins. The one exception is a single source, chosen in the configuration word, which is promoted above all the others. A new request reaches the host only if it outranks everything currently in service. The state of the inputs can change between the moment the host sees the request and the moment it acknowledges, for example when a source drops or is masked in that window. In that case the acknowledge returns the reserved error vector 0 and marks nothing as in service.

Top module: `vpic`

## Requirements
- R1: Registers are selected by bus_addr_i: 0 configuration, 1 mask, 2 in-service, 3 vector. A read returns the register on bus_rdata_o in the same cycle, and after reset every register reads zero.
- R2: Source n (n = 1..31) is eligible only while src_i[n] is high and mask bit n is 1. The mask resets to all zeros, so no source is eligible after reset.
- R3: Configuration bit 0 is the global enable. While it is 0, irq_o stays low whatever sources are pending.
- R4: A write to the vector register with bit 0 set latches the vector. Reading the register then returns the source number in bits 15:11 and zeros in every other bit. A write with bit 0 clear leaves both the vector and the in-service set unchanged.
- R5: An acknowledge that returns a real source sets that source's in-service bit.
- R6: A write to the in-service register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Among eligible sources, the lowest number wins.
- R8: Configuration bits 12:8 name one source that outranks all others.
- R9: irq_o is high only when the winning eligible source outranks every in-service source and the global enable is set.
- R10: An acknowledge while irq_o is low latches vector 0 and leaves the in-service set unchanged.
- R11: Configuration bits 17:13 drive irq_level_o directly.
- R12: Source 0 is reserved for the error vector. src_i[0] never raises a request and is never set in service.
- R13: Inputs are level-sensitive. When a pending input drops, its request is withdrawn in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt inputs, bit n is source n |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Request to host |
| irq_level_o | output | 5 | Request level presented to host |

## Verification
The bench drives a source that is withdrawn, and separately one that is masked, after the request was raised and before the acknowledge. A design that latched a stale winner would return a real vector and leave a phantom in-service bit, where vector 0 is expected. It checks that a lower-ranked source stays blocked while a higher one is in service and that a higher-ranked one still preempts. A design that ignored the in-service set would raise irq_o when it should stay low. It also writes in-service words whose ones fall on idle bits, and acknowledge writes with bit 0 clear. A design with plain-write or toggle semantics would wipe or alter the live in-service state. Finally it promotes a high-numbered source to check that the override beats numeric order, and asserts source 0 to check that the reserved number is never granted.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_MASK = 2'd1,
    REG_ISR  = 2'd2,
    REG_VEC  = 2'd3
  } reg_sel_e;

  localparam int unsigned CFG_GIE_BIT = 0;
  localparam int unsigned CFG_TOP_LSB = 8;
  localparam int unsigned CFG_LVL_LSB = 13;
  localparam int unsigned VEC_ACK_BIT = 0;
  localparam int unsigned VEC_SHIFT   = 11;
endpackage

// File: rtl/vpic_pick.sv
module vpic_pick #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned VW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [VW-1:0]    top_i,
  output logic             found_o,
  output logic [VW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VW'(i);
    end
    if (req_i[top_i]) idx_o = top_i;
  end

  assign found_o = |req_i;
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned VW = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             grant_ok_i,
  input  logic [VW-1:0]    grant_idx_i,
  output logic             gie_o,
  output logic [VW-1:0]    top_o,
  output logic [VW-1:0]    lvl_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] isr_o,
  output logic [VW-1:0]    vec_o
);
  logic wr_cfg, wr_mask, wr_isr, ack;

  assign wr_cfg  = bus_sel_i && bus_we_i && (bus_addr_i == REG_CFG);
  assign wr_mask = bus_sel_i && bus_we_i && (bus_addr_i == REG_MASK);
  assign wr_isr  = bus_sel_i && bus_we_i && (bus_addr_i == REG_ISR);
  assign ack     = bus_sel_i && bus_we_i && (bus_addr_i == REG_VEC)
                   && bus_wdata_i[VEC_ACK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_o <= 1'b0;
      top_o <= '0;
      lvl_o <= '0;
    end else if (wr_cfg) begin
      gie_o <= bus_wdata_i[CFG_GIE_BIT];
      top_o <= bus_wdata_i[CFG_TOP_LSB +: VW];
      lvl_o <= bus_wdata_i[CFG_LVL_LSB +: VW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_o <= '0;
    else if (wr_mask) mask_o <= bus_wdata_i[N_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_o <= '0;
    end else if (wr_isr) begin
      isr_o <= isr_o & ~bus_wdata_i[N_SRC-1:0];
    end else if (ack && grant_ok_i) begin
      isr_o[grant_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  vec_o <= '0;
    else if (ack) vec_o <= grant_ok_i ? grant_idx_i : '0;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      REG_CFG: begin
        bus_rdata_o[CFG_GIE_BIT]         = gie_o;
        bus_rdata_o[CFG_TOP_LSB +: VW]   = top_o;
        bus_rdata_o[CFG_LVL_LSB +: VW]   = lvl_o;
      end
      REG_MASK: bus_rdata_o[N_SRC-1:0] = mask_o;
      REG_ISR:  bus_rdata_o[N_SRC-1:0] = isr_o;
      REG_VEC:  bus_rdata_o[VEC_SHIFT +: VW] = vec_o;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vpic.sv
module vpic
  import vpic_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned VW = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_o,
  output logic [VW-1:0]    irq_level_o
);
  logic             gie;
  logic [VW-1:0]    top_sel, lvl;
  logic [N_SRC-1:0] mask_q, isr_q, elig;
  logic [VW-1:0]    vec_q;
  logic             p_found, s_found, outranks, grant_ok;
  logic [VW-1:0]    p_idx, s_idx;

  vpic_regs #(.N_SRC(N_SRC), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .grant_ok_i  (grant_ok),
    .grant_idx_i (p_idx),
    .gie_o       (gie),
    .top_o       (top_sel),
    .lvl_o       (lvl),
    .mask_o      (mask_q),
    .isr_o       (isr_q),
    .vec_o       (vec_q)
  );

  // source 0 carries the error vector, never a real request
  assign elig = src_i & mask_q & ~N_SRC'(1);

  vpic_pick #(.N_SRC(N_SRC)) u_pend (
    .req_i   (elig),
    .top_i   (top_sel),
    .found_o (p_found),
    .idx_o   (p_idx)
  );

  vpic_pick #(.N_SRC(N_SRC)) u_serv (
    .req_i   (isr_q),
    .top_i   (top_sel),
    .found_o (s_found),
    .idx_o   (s_idx)
  );

  always_comb begin
    if (p_idx == s_idx)        outranks = 1'b0;
    else if (p_idx == top_sel) outranks = 1'b1;
    else if (s_idx == top_sel) outranks = 1'b0;
    else                       outranks = p_idx < s_idx;
  end

  assign grant_ok    = gie && p_found && (!s_found || outranks);
  assign irq_o       = grant_ok;
  assign irq_level_o = lvl;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned VW = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic             irq_o,
  input logic [VW-1:0]    irq_level_o,
  input logic [N_SRC-1:0] isr_q,
  input logic [VW-1:0]    vec_q
);
  logic wr_cfg, wr_isr, ack;
  assign wr_cfg = bus_sel_i && bus_we_i && bus_addr_i == 2'd0;
  assign wr_isr = bus_sel_i && bus_we_i && bus_addr_i == 2'd2;
  assign ack    = bus_sel_i && bus_we_i && bus_addr_i == 2'd3 && bus_wdata_i[0];

  AST_ISR_ONES_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_isr |=> (isr_q & $past(bus_wdata_i[N_SRC-1:0])) == '0); // R6
  AST_ISR_ZEROS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_isr |=> (isr_q & ~$past(bus_wdata_i[N_SRC-1:0]))
               == ($past(isr_q) & ~$past(bus_wdata_i[N_SRC-1:0]))); // R6
  AST_GIE_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !bus_wdata_i[0]) |=> !irq_o); // R3
  AST_ERR_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !irq_o) |=> (vec_q == '0) && $stable(isr_q)); // R10
  AST_ACK_ADDS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && irq_o) |=> $countones(isr_q) == $countones($past(isr_q)) + 1); // R5
  AST_SRC0_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isr_q[0]); // R12
  AST_LEVEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(irq_level_o)); // R11
endmodule

bind vpic vpic_chk #(.N_SRC(N_SRC), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .irq_level_o (irq_level_o),
  .isr_q       (isr_q),
  .vec_q       (vec_q)
);

// File: tb/vpic_bench.sv
module vpic_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  logic [4:0]  irq_level_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  vpic u_vpic (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0; bus_wdata_i = '0;
  endtask

  // driver: push the expected read value, monitor compares it
  task automatic rd(logic [1:0] a, logic [31:0] e, string tag);
    @(negedge clk_i);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    @(negedge clk_i);
    bus_sel_i = 0;
  endtask

  task automatic irq_is(logic e, string tag);
    @(negedge clk_i);
    chk(tag, {31'b0, irq_o}, {31'b0, e});
  endtask

  // monitor
  always @(posedge clk_i) begin
    if (rst_ni && bus_sel_i && !bus_we_i) begin
      if (exp_q.size() == 0) chk("monitor underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    rd(0, 0, "R1 cfg reset");
    rd(1, 0, "R2 mask reset");
    rd(2, 0, "R1 isr reset");
    rd(3, 0, "R1 vec reset");
    src_i = 32'hFFFF_FFFE;
    wr(0, 32'h1);
    irq_is(0, "R2 all masked");
    wr(0, 32'h0);
    src_i = 32'h30;
    wr(1, 32'h30);
    irq_is(0, "R3 enable off");
    wr(0, 32'h1);
    irq_is(1, "R3 enable on");
    wr(3, 32'h1);
    rd(3, 32'h2000, "R7 lowest wins vec 4");
    rd(2, 32'h10, "R5 isr set 4");
    irq_is(0, "R9 lower blocked by in-service");
    wr(3, 32'h0);
    rd(3, 32'h2000, "R4 no-ack write keeps vec");
    rd(2, 32'h10, "R4 no-ack write keeps isr");
    wr(2, 32'h20);
    rd(2, 32'h10, "R6 zero bits keep");
    wr(2, 32'h10);
    rd(2, 32'h0, "R6 one bit clears");
    irq_is(1, "R9 request returns");
    wr(0, 32'h501);
    rd(0, 32'h501, "R1 cfg readback");
    wr(3, 32'h1);
    rd(3, 32'h2800, "R8 promoted source 5");
    irq_is(0, "R8 4 below promoted 5");
    wr(2, 32'h20);
    wr(0, 32'h1);
    wr(3, 32'h1);
    rd(2, 32'h10, "R5 isr 4 again");
    src_i = 32'h34;
    wr(1, 32'h34);
    irq_is(1, "R9 higher preempts in-service");
    wr(3, 32'h1);
    rd(3, 32'h1000, "R4 vec 2");
    rd(2, 32'h14, "R5 isr 2 and 4");
    irq_is(0, "R9 nothing outranks 2");
    wr(2, 32'h14);
    irq_is(1, "R13 pending 2");
    src_i = 32'h0;
    irq_is(0, "R13 withdrawn drops irq");
    wr(3, 32'h1);
    rd(3, 32'h0, "R10 withdrawn gives vec 0");
    rd(2, 32'h0, "R10 isr untouched");
    src_i = 32'h30;
    wr(1, 32'h30);
    wr(3, 32'h1);
    rd(3, 32'h2000, "R4 vec 4 before mask race");
    wr(2, 32'h10);
    wr(1, 32'h0);
    wr(3, 32'h1);
    rd(3, 32'h0, "R10 masked gives vec 0");
    rd(2, 32'h0, "R10 isr still empty");
    src_i = 32'h1;
    wr(1, 32'h1);
    irq_is(0, "R12 source 0 no request");
    wr(3, 32'h1);
    rd(2, 32'h0, "R12 source 0 not in service");
    wr(0, 32'h22001);
    @(negedge clk_i);
    chk("R11 level output", {27'b0, irq_level_o}, 32'd17);
    rd(0, 32'h22001, "R11 level readback");
    src_i = 32'h30;
    wr(1, 32'h30);
    irq_is(1, "R13 asserted again");
    wr(0, 32'h22000);
    irq_is(0, "R3 enable cleared");
    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) chk("scoreboard drain", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule